// File: doc/BRIEF.md
# Serial Peripheral Master with Word Queues

This block is a memory-mapped serial peripheral (SPI) master. A 32-bit register port sets the bit-clock divider, the word length (8 or 16 bits), the clock polarity and phase, and the bit order. It also loads a four-word transmit queue and drains a four-word receive queue. The chip-select lines are not part of the block. They are driven from general-purpose pins outside it.

Software works in batches. In configuration mode it sets the format, writes up to four words into the data register and switches to active mode. It then waits until the receive fill level reaches a programmed threshold, which raises the interrupt, and reads the same number of words back. Every word that goes out on MOSI brings one word in from MISO. The format registers are locked while the block is active, so a batch is never shifted with a mixed format.

Top module: `spim_top`

## Requirements
- R1: After reset the block is in configuration mode and both queues are empty. The control register at 0x00 reads 0x40. The register at 0x04 reads 0. The register at 0x08 reads 0x0108, which is divider 1 and 8-bit words. Status at 0x14 reads 0x0004. SCK, MOSI and the interrupt are low.
- R2: Control register 0x00 holds the mode in bits [7:6]: 01 is configuration and 10 is active. Writing any other code leaves the mode unchanged. The format fields of register 0x04 are polarity (bit 0), phase (bit 1) and bit order (bit 2). These fields and the whole of register 0x08 take a write only in configuration mode. Interrupt enable (bit 9) and level (bits [13:12]) of 0x04 can be written in either mode.
- R3: A write to 0x18 pushes the low 16 bits into the transmit queue. A read of 0x18 pops the receive queue. Each queue holds 4 words. A push into a full transmit queue is dropped. A read of an empty receive queue returns 0. Status bits [13:11] give the transmit count and bits [10:8] give the receive count.
- R4: Writing 1 to bit 0 of 0x00 empties both queues.
- R5: Register 0x08 bits [15:8] hold the divider n. Each bit lasts n+1 clock cycles. A written 0 is stored as 1.
- R6: Register 0x08 bits [4:0] set the word length. A value of 16 selects 16-bit words, and any other value selects 8-bit words, which read back as 8. An 8-bit word uses data bits [7:0].
- R7: With the shifter idle, SCK sits at the polarity level. With phase 0, MOSI is sampled on the edge leaving the idle level. With phase 1, it is sampled on the edge returning to the idle level.
- R8: With bit order 1 the word goes out most significant bit first. With bit order 0 it goes out least significant bit first.
- R9: Each word sent captures one MISO word, assembled in the same bit order, and pushes it into the receive queue.
- R10: Words are shifted only in active mode, and only while the stop bit (bit 1 of 0x00) is clear. A word starts whenever the transmit queue holds data and the shifter is idle.
- R11: Status bit 14 is set while the receive count is at least level+1, and clears when the count falls below that. The interrupt output is this flag gated by the enable bit.
- R12: Status bit 2 is 1 exactly when no word is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data address) |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sck | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Receive-level interrupt |

## Verification
The assertions assume the following about the register port:
- Read and write strobes are never raised together.
- Each strobe lasts one clock.
- Addresses are word aligned.

The bench drives every access through one read task and one write task that honour these rules.

The assertions also take MISO to be stable around the sampling edge. The bench meets this by returning the inverse of MOSI, which changes only at slot starts, far from a sampling edge. Format changes are issued only in configuration mode, so the monitor's edge reconstruction never sees a format change in the middle of a word.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int SPIM_DIV_W = 8;

    localparam logic [4:0] A_MCTL = 5'h00;
    localparam logic [4:0] A_CTL0 = 5'h04;
    localparam logic [4:0] A_CTL1 = 5'h08;
    localparam logic [4:0] A_STAT = 5'h14;
    localparam logic [4:0] A_DATA = 5'h18;

    localparam logic [1:0] MODE_CFG = 2'b01;
    localparam logic [1:0] MODE_RUN = 2'b10;

    typedef struct packed {
        logic [1:0]            mode;
        logic                  stop;
        logic                  cpol;
        logic                  cpha;
        logic                  msb;
        logic                  rxie;
        logic [1:0]            lvl;
        logic [SPIM_DIV_W-1:0] div;
        logic                  w16;
    } spim_regs_t;

    localparam spim_regs_t SPIM_REGS_RST = '{
        mode: MODE_CFG, stop: 1'b0, cpol: 1'b0, cpha: 1'b0, msb: 1'b0,
        rxie: 1'b0, lvl: 2'd0, div: SPIM_DIV_W'(1), w16: 1'b0
    };
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        if (clr) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = wdata;
                s_d.wp          = nxt(s_q.wp);
            end
            if (do_pop) begin
                s_d.rp = nxt(s_q.rp);
            end
            s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;
    assign empty = (s_q.cnt == '0);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int WMAX  = 16,
    parameter int DIV_W = 8,
    localparam int IDX_W = $clog2(WMAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WMAX-1:0]  word,
    input  logic             w16,
    input  logic             msb,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             busy,
    output logic             fin,
    output logic [WMAX-1:0]  rx_word,
    output logic             sck,
    output logic             mosi
);
    typedef struct packed {
        logic             busy;
        logic [DIV_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [WMAX-1:0]  txw;
        logic [WMAX-1:0]  rxw;
        logic             w16;
        logic             msb;
        logic             cpha;
        logic [DIV_W-1:0] div;
    } sh_st_t;

    sh_st_t           s_q, s_d;
    logic [DIV_W:0]   half_sum;
    logic [DIV_W:0]   half_v;
    logic [DIV_W-1:0] half_m1;
    logic [IDX_W-1:0] last;
    logic [IDX_W-1:0] pos;
    logic             active_lvl;
    logic             slot_end;

    always_comb begin
        half_sum   = {1'b0, s_q.div} + (DIV_W+1)'(1);
        half_v     = half_sum >> 1;
        half_m1    = half_v[DIV_W-1:0] - DIV_W'(1);
        last       = s_q.w16 ? IDX_W'(WMAX - 1) : IDX_W'(WMAX/2 - 1);
        pos        = s_q.msb ? (last - s_q.idx) : s_q.idx;
        active_lvl = s_q.cpha ? (s_q.cnt <= half_m1) : (s_q.cnt > half_m1);
        slot_end   = (s_q.cnt == s_q.div);
        fin        = s_q.busy && slot_end && (s_q.idx == last);

        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.idx  = '0;
                s_d.txw  = word;
                s_d.rxw  = '0;
                s_d.w16  = w16;
                s_d.msb  = msb;
                s_d.cpha = cpha;
                s_d.div  = div;
            end
        end else begin
            if (s_q.cnt == half_m1) begin
                s_d.rxw[pos] = miso;
            end
            if (slot_end) begin
                s_d.cnt = '0;
                if (s_q.idx == last) s_d.busy = 1'b0;
                else                 s_d.idx  = s_q.idx + IDX_W'(1);
            end else begin
                s_d.cnt = s_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign rx_word = s_q.rxw;
    assign sck     = s_q.busy ? (cpol ^ active_lvl) : cpol;
    assign mosi    = s_q.busy ? s_q.txw[pos] : 1'b0;
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int WORD_MAX   = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        irq
);
    spim_regs_t r_q, r_d;

    logic                  tx_push, tx_pop, rx_pop, fifo_clr;
    logic [WORD_MAX-1:0]   tx_head, rx_head, sh_rx;
    logic [CNT_W-1:0]      tx_cnt, rx_cnt;
    logic                  tx_empty, rx_empty;
    logic                  sh_busy, sh_fin, sh_start;
    logic                  lvl_hit;
    logic                  cfg_mode;
    logic [1:0]            cur_mode;
    logic                  cur_cpol;
    logic [SPIM_DIV_W-1:0] cur_div;
    logic [1:0]            cur_lvl;
    logic [SPIM_DIV_W-1:0] div_wr;
    logic                  unused_ok;

    assign cur_mode  = r_q.mode;
    assign cur_cpol  = r_q.cpol;
    assign cur_div   = r_q.div;
    assign cur_lvl   = r_q.lvl;
    assign unused_ok = ^reg_wdata;

    always_comb begin
        r_d      = r_q;
        tx_push  = 1'b0;
        rx_pop   = 1'b0;
        fifo_clr = 1'b0;
        cfg_mode = (r_q.mode == MODE_CFG);
        lvl_hit  = (rx_cnt > CNT_W'(r_q.lvl));
        div_wr   = (reg_wdata[15:8] == '0) ? SPIM_DIV_W'(1) : reg_wdata[15:8];

        if (reg_wr) begin
            unique case (reg_addr)
                A_MCTL: begin
                    if (reg_wdata[7:6] == MODE_CFG || reg_wdata[7:6] == MODE_RUN)
                        r_d.mode = reg_wdata[7:6];
                    r_d.stop = reg_wdata[1];
                    fifo_clr = reg_wdata[0];
                end
                A_CTL0: begin
                    r_d.rxie = reg_wdata[9];
                    r_d.lvl  = reg_wdata[13:12];
                    if (cfg_mode) begin
                        r_d.cpol = reg_wdata[0];
                        r_d.cpha = reg_wdata[1];
                        r_d.msb  = reg_wdata[2];
                    end
                end
                A_CTL1: begin
                    if (cfg_mode) begin
                        r_d.div = div_wr;
                        r_d.w16 = (reg_wdata[4:0] == 5'd16);
                    end
                end
                A_DATA:  tx_push = 1'b1;
                default: ;
            endcase
        end

        rx_pop   = reg_rd && (reg_addr == A_DATA);
        sh_start = (r_q.mode == MODE_RUN) && !r_q.stop && !sh_busy && !tx_empty;
        tx_pop   = sh_start;

        reg_rdata = '0;
        unique case (reg_addr)
            A_MCTL: reg_rdata = {24'd0, r_q.mode, 4'd0, r_q.stop, 1'b0};
            A_CTL0: reg_rdata = {18'd0, r_q.lvl, 2'd0, r_q.rxie, 6'd0,
                                 r_q.msb, r_q.cpha, r_q.cpol};
            A_CTL1: reg_rdata = {16'd0, r_q.div, 3'd0, r_q.w16 ? 5'd16 : 5'd8};
            A_STAT: reg_rdata = {17'd0, lvl_hit, 3'(tx_cnt), 3'(rx_cnt),
                                 5'd0, !sh_busy, 2'd0};
            A_DATA: reg_rdata = rx_empty ? 32'd0 : {16'd0, 16'(rx_head)};
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SPIM_REGS_RST;
        else        r_q <= r_d;
    end

    assign irq = lvl_hit && r_q.rxie;

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_MAX)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(tx_push), .wdata(reg_wdata[WORD_MAX-1:0]), .pop(tx_pop),
        .head(tx_head), .count(tx_cnt), .empty(tx_empty)
    );

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_MAX)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(sh_fin), .wdata(sh_rx), .pop(rx_pop),
        .head(rx_head), .count(rx_cnt), .empty(rx_empty)
    );

    spim_shift #(.WMAX(WORD_MAX), .DIV_W(SPIM_DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .word(tx_head),
        .w16(r_q.w16), .msb(r_q.msb), .cpol(r_q.cpol), .cpha(r_q.cpha),
        .div(r_q.div), .miso(miso), .busy(sh_busy), .fin(sh_fin),
        .rx_word(sh_rx), .sck(sck), .mosi(mosi)
    );
endmodule

// File: rtl/spim_checker.sv
module spim_checker
    import spim_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [4:0]            reg_addr,
    input logic [31:0]           reg_wdata,
    input logic                  sck,
    input logic                  irq,
    input logic [1:0]            cur_mode,
    input logic                  cur_cpol,
    input logic [SPIM_DIV_W-1:0] cur_div,
    input logic [1:0]            cur_lvl,
    input logic                  sh_busy,
    input logic [CNT_W-1:0]      tx_cnt,
    input logic [CNT_W-1:0]      rx_cnt
);
    assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> (sck == cur_cpol));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MCTL && reg_wdata[0]) |=> (tx_cnt == '0 && rx_cnt == '0));

    assert_cfg_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_RUN) |=> $stable(cur_div));

    assert_div_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_div != '0);

    assert_no_shift_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_RUN && !sh_busy) |=> !sh_busy);

    assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_cnt > CNT_W'(cur_lvl)));
endmodule

bind spim_top spim_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sck(sck), .irq(irq), .cur_mode(cur_mode),
    .cur_cpol(cur_cpol), .cur_div(cur_div), .cur_lvl(cur_lvl),
    .sh_busy(sh_busy), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_spim_top.sv
`timescale 1ns/1ps
module test_spim_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = 5'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        sck, mosi, miso, irq;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign miso = ~mosi;

    spim_top i_spim_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
    );

    // serial monitor
    logic        mon_cpol = 1'b0, mon_cpha = 1'b0, mon_msb = 1'b0, mon_w16 = 1'b0;
    int          mon_div = 1;
    logic        sck_prev = 1'b0;
    int          ebits = 0, last_t = 0, per_bad = 0;
    logic [15:0] capw [4];

    always @(negedge clk) begin
        if (sck !== sck_prev) begin
            if ((sck != mon_cpol) ^ mon_cpha) begin
                automatic int nb = mon_w16 ? 16 : 8;
                automatic int wi = ebits / nb;
                automatic int bi = ebits % nb;
                if (bi > 0 && (cyc - last_t) != mon_div + 1) per_bad++;
                last_t = cyc;
                if (wi < 4) begin
                    if (mon_msb) capw[wi][nb-1-bi] = mosi;
                    else         capw[wi][bi] = mosi;
                end
                ebits++;
            end
        end
        sck_prev = sck;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(5'h14, s);
            if (s[2] && s[13:11] == 3'd0) break;
        end
    endtask

    task automatic mon_reset();
        ebits = 0; per_bad = 0;
        for (int k = 0; k < 4; k++) capw[k] = 16'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] tw [4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, d); check("R1 mctl", d, 32'h40);
        rd(5'h04, d); check("R1 ctl0", d, 32'h0);
        rd(5'h08, d); check("R1 ctl1", d, 32'h0108);
        rd(5'h14, d); check("R1 status", d, 32'h0004);
        check("R1 pins", {29'd0, sck, mosi, irq}, 32'd0);

        // R3 overfill, empty pop
        for (int k = 0; k < 5; k++) wr(5'h18, 32'h100 + k);
        rd(5'h14, d); check("R3 tx count full", {29'd0, d[13:11]}, 32'd4);
        rd(5'h18, d); check("R3 empty pop", d, 32'd0);
        // R10 no shifting in configuration mode
        repeat (40) @(negedge clk);
        rd(5'h14, d); check("R10 cfg holds tx", {29'd0, d[13:11]}, 32'd4);
        // R10 stop bit holds
        wr(5'h00, 32'h82);
        repeat (40) @(negedge clk);
        rd(5'h14, d); check("R10 stop holds tx", {29'd0, d[13:11]}, 32'd4);
        check("R10 stop sck idle", {31'd0, sck}, 32'd0);
        wr(5'h00, 32'h80);
        wait_done();
        rd(5'h14, d); check("R3 rx count", {29'd0, d[10:8]}, 32'd4);
        for (int k = 0; k < 4; k++) begin
            rd(5'h18, d); check("R3 fifth dropped / R9", d, {24'd0, ~(8'(k))});
        end

        // R2 config lock
        wr(5'h04, 32'h0000_3207);
        wr(5'h08, 32'h0000_0910);
        rd(5'h04, d); check("R2 ctl0 locked fmt", d, 32'h3200);
        rd(5'h08, d); check("R2 ctl1 locked", d, 32'h0108);
        wr(5'h00, 32'hC0);
        rd(5'h00, d); check("R2 bad mode ignored", d, 32'h80);
        wr(5'h00, 32'h41);
        wr(5'h08, 32'h0000_0013);
        rd(5'h08, d); check("R5 R6 div0 clamp len", d, 32'h0108);

        // R4 clear
        wr(5'h18, 32'h5);
        wr(5'h18, 32'h6);
        wr(5'h00, 32'h41);
        rd(5'h14, d); check("R4 cleared", {26'd0, d[13:8]}, 32'd0);

        // R11 level sweep
        wr(5'h08, 32'h0108);
        for (int lv = 0; lv < 5; lv++) begin
            automatic int L = (lv == 4) ? 0 : lv;
            automatic logic en = (lv != 4);
            wr(5'h00, 32'h41);
            wr(5'h04, {18'd0, 2'(L), 2'd0, en, 9'd0});
            wr(5'h00, 32'h80);
            for (int k = 1; k <= 4; k++) begin
                wr(5'h18, 32'(k));
                wait_done();
                rd(5'h14, d);
                check("R11 flag after push", {31'd0, d[14]}, {31'd0, k > L});
                check("R11 irq after push", {31'd0, irq}, {31'd0, en && (k > L)});
            end
            for (int k = 3; k >= 0; k--) begin
                rd(5'h18, d);
                rd(5'h14, d);
                check("R11 flag after pop", {31'd0, d[14]}, {31'd0, k > L});
            end
        end

        // R12 idle bit during a slow word
        wr(5'h00, 32'h41);
        wr(5'h08, 32'h0910);
        wr(5'h18, 32'hABCD);
        wr(5'h00, 32'h80);
        repeat (4) @(negedge clk);
        rd(5'h14, d); check("R12 busy", {31'd0, d[2]}, 32'd0);
        wait_done();
        rd(5'h14, d); check("R12 idle", {31'd0, d[2]}, 32'd1);
        rd(5'h18, d); check("R9 16-bit", d, 32'h5432);

        // format sweep
        for (int c = 0; c < 64; c++) begin
            automatic logic p = c[0], h = c[1], m = c[2], w = c[3];
            automatic int dv = (c[5:4] == 0) ? 1 : (c[5:4] == 1) ? 2 : (c[5:4] == 2) ? 5 : 9;
            automatic int nb = w ? 16 : 8;
            automatic logic [15:0] mask = w ? 16'hFFFF : 16'h00FF;
            wr(5'h00, 32'h41);
            wr(5'h04, {18'd0, 2'd3, 2'd0, 1'b1, 6'd0, m, h, p});
            wr(5'h08, {16'd0, 8'(dv), 3'd0, w ? 5'd16 : 5'd8});
            mon_cpol = p; mon_cpha = h; mon_msb = m; mon_w16 = w; mon_div = dv;
            repeat (2) @(negedge clk);
            mon_reset();
            check("R7 idle level", {31'd0, sck}, {31'd0, p});
            for (int k = 0; k < 4; k++) begin
                tw[k] = 16'((c * 16'h2F1B + k * 16'h9E37 + 16'h51) & 16'hFFFF);
                wr(5'h18, {16'd0, tw[k]});
            end
            check("R11 no irq before run", {31'd0, irq}, 32'd0);
            wr(5'h00, 32'h80);
            wait_done();
            rd(5'h14, d);
            check("R9 rx count", {29'd0, d[10:8]}, 32'd4);
            check("R11 irq at level", {31'd0, irq}, 32'd1);
            for (int k = 0; k < 4; k++) begin
                rd(5'h18, d);
                check("R9 rx word", d, {16'd0, ~tw[k] & mask});
                check("R8 R7 mosi word", {16'd0, capw[k]}, {16'd0, tw[k] & mask});
            end
            check("R5 bit period", per_bad, 0);
            check("R6 bit count", ebits, 4 * nb);
            check("R11 irq after drain", {31'd0, irq}, 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule